// File: doc/BRIEF.md
# Dual-Rail Power Sequencer with Latched Fault Shutdown

This block brings up a positive and a negative supply rail in a fixed order and then watches both for faults. When the enable input goes high and the input supply is above its lockout level, the positive converter is switched on at once. Its switch current limit starts in a reduced soft-start setting, and that limit is released after a programmable time. The negative converter follows after a fixed delay.

Two comparator flags are filtered over a millisecond-scale window: one reports that the positive rail is low, the other that the negative rail is out of regulation. A fault is latched when either flag stays asserted for the whole window. An over-temperature flag latches the same fault at once. A latched fault turns both converters off and switches on the output discharge. The latch clears only when the enable is taken low and raised again, when the supply drops into lockout, or on power-on reset.

All times come from the clock. They are set by a clocks-per-millisecond parameter and a millisecond count for each interval.

Top module: `pwr_seq_supervisor`

## Requirements
- R1: After reset, pos_en_o, soft_start_o, neg_en_o and fault_o are 0 and discharge_o is 1.
- R2: With en_i = 1, uvlo_i = 0 and otemp_i = 0 in the off state, pos_en_o and soft_start_o are 1 from the next clock edge, and discharge_o is 0.
- R3: soft_start_o stays 1 for exactly SOFT_MS*CLKS_PER_MS cycles after pos_en_o rises and is 0 afterwards. soft_start_o is never 1 while pos_en_o is 0.
- R4: neg_en_o rises exactly NEG_DELAY_MS*CLKS_PER_MS cycles after pos_en_o rises, and is never 1 while pos_en_o is 0.
- R5: A fault latches when pos_low_i is sampled 1 on FILT_MS*CLKS_PER_MS consecutive edges while the positive converter is on. A single edge with pos_low_i = 0 restarts that count from zero.
- R6: neg_oor_i uses the same filter, but only while neg_en_o is 1. Before the negative converter is on, neg_oor_i has no effect for any length of time.
- R7: In the latched fault, the outputs are fault_o = 1, discharge_o = 1 and all enables 0. This state holds while en_i stays 1 and uvlo_i stays 0, even after every fault flag clears.
- R8: otemp_i = 1 with en_i = 1 and uvlo_i = 0 enters the latched fault on the next edge. From the off state this replaces the start-up.
- R9: Taking en_i low clears the latched fault (fault_o = 0, discharge_o = 1). A later en_i = 1 starts the sequence again from R2.
- R10: en_i = 0 in any state gives, from the next edge, all enables 0, discharge_o = 1 and fault_o = 0.
- R11: uvlo_i = 1 in any state, including the latched fault, gives the off outputs of R10 from the next edge and never sets fault_o. While uvlo_i stays 1, the block does not start even with en_i = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low power-on reset |
| en_i | input | 1 | Enable; a low-to-high toggle clears a latched fault |
| uvlo_i | input | 1 | Input supply below lockout level |
| otemp_i | input | 1 | Junction over temperature |
| pos_low_i | input | 1 | Positive rail below its fault threshold |
| neg_oor_i | input | 1 | Negative rail out of regulation |
| pos_en_o | output | 1 | Positive converter enable |
| soft_start_o | output | 1 | Reduced switch current limit request |
| neg_en_o | output | 1 | Negative converter enable |
| discharge_o | output | 1 | Active output discharge |
| fault_o | output | 1 | Latched fault shutdown |

## Verification
The bench pulses the fault flags for one cycle less than the filter window, drops them for a single cycle and raises them again. A filter that did not restart its count, or that tripped one cycle early, would latch a fault here. It holds the negative-rail flag high during the start delay, longer than the window, to catch a filter that is armed too soon. It measures the soft-start and negative-start delays to the exact cycle, which exposes off-by-one counters. It also checks lockout and enable-low from the latched state, so a latch that ignores the power-cycle exit, or one that sets the fault on lockout, would show up.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;

   typedef enum logic [1:0] {
      SEQ_IDLE  = 2'd0,
      SEQ_RAMP  = 2'd1,
      SEQ_RUN   = 2'd2,
      SEQ_TRIP  = 2'd3
   } seq_state_t;

   localparam int N_WATCH = 2;
   localparam int W_POS   = 0;
   localparam int W_NEG   = 1;

endpackage

// File: rtl/pseq_span_timer.sv
module pseq_span_timer #(
   parameter int LIMIT = 4
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic run_i,
   output logic last_o,
   output logic window_o
);
   localparam int CW = $clog2(LIMIT + 1);
   localparam logic [CW-1:0] TOP  = CW'(LIMIT);
   localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

   logic [CW-1:0] cnt_q;

   initial begin
      assert (LIMIT >= 1) else $error("pseq_span_timer: LIMIT must be at least 1");
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)             cnt_q <= '0;
      else if (!run_i)         cnt_q <= '0;
      else if (cnt_q != TOP)   cnt_q <= cnt_q + 1'b1;
   end

   assign last_o   = run_i && (cnt_q == LAST);
   assign window_o = (cnt_q < TOP);

   AST_TMR_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !run_i |=> (cnt_q == '0)); // R5
   AST_TMR_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cnt_q <= TOP); // R3

endmodule

// File: rtl/pseq_ctrl_fsm.sv
module pseq_ctrl_fsm
   import pwr_seq_pkg::*;
(
   input  logic       clk_i,
   input  logic       rst_ni,
   input  logic       en_i,
   input  logic       uvlo_i,
   input  logic       otemp_i,
   input  logic       ramp_done_i,
   input  logic       trip_i,
   output seq_state_t st_o
);
   seq_state_t st_q, st_d;

   always_comb begin
      st_d = st_q;
      if (uvlo_i || !en_i) begin
         st_d = SEQ_IDLE;
      end else if (otemp_i) begin
         st_d = SEQ_TRIP;
      end else begin
         unique case (st_q)
            SEQ_IDLE: st_d = SEQ_RAMP;
            SEQ_RAMP: begin
               if (trip_i)           st_d = SEQ_TRIP;
               else if (ramp_done_i) st_d = SEQ_RUN;
            end
            SEQ_RUN:  if (trip_i) st_d = SEQ_TRIP;
            SEQ_TRIP: st_d = SEQ_TRIP;
            default:  st_d = SEQ_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) st_q <= SEQ_IDLE;
      else         st_q <= st_d;
   end

   assign st_o = st_q;

   AST_UVLO_FORCES_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      uvlo_i |=> (st_q == SEQ_IDLE)); // R11
   AST_EN_LOW_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !en_i |=> (st_q == SEQ_IDLE)); // R10
   AST_TRIP_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (st_q == SEQ_TRIP && en_i && !uvlo_i) |=> (st_q == SEQ_TRIP)); // R7
   AST_HOT_TRIPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (en_i && !uvlo_i && otemp_i) |=> (st_q == SEQ_TRIP)); // R8
   AST_NO_SKIP_RAMP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (st_q == SEQ_IDLE) |=> (st_q != SEQ_RUN)); // R4

endmodule

// File: rtl/pwr_seq_supervisor.sv
module pwr_seq_supervisor
   import pwr_seq_pkg::*;
#(
   parameter int CLKS_PER_MS  = 50000,
   parameter int NEG_DELAY_MS = 10,
   parameter int SOFT_MS      = 1,
   parameter int FILT_MS      = 3
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic en_i,
   input  logic uvlo_i,
   input  logic otemp_i,
   input  logic pos_low_i,
   input  logic neg_oor_i,
   output logic pos_en_o,
   output logic soft_start_o,
   output logic neg_en_o,
   output logic discharge_o,
   output logic fault_o
);
   localparam int NEG_CYC  = CLKS_PER_MS * NEG_DELAY_MS;
   localparam int SOFT_CYC = CLKS_PER_MS * SOFT_MS;
   localparam int FILT_CYC = CLKS_PER_MS * FILT_MS;

   initial begin
      assert (CLKS_PER_MS >= 1)  else $error("pwr_seq_supervisor: CLKS_PER_MS < 1");
      assert (NEG_DELAY_MS >= 1) else $error("pwr_seq_supervisor: NEG_DELAY_MS < 1");
      assert (SOFT_MS >= 1)      else $error("pwr_seq_supervisor: SOFT_MS < 1");
      assert (FILT_MS >= 1)      else $error("pwr_seq_supervisor: FILT_MS < 1");
   end

   seq_state_t          st;
   logic                ramp_done;
   logic                ramp_win_unused;
   logic                soft_win;
   logic                soft_last_unused;
   logic [N_WATCH-1:0]  flag_vec;
   logic [N_WATCH-1:0]  arm_vec;
   logic [N_WATCH-1:0]  trip_vec;
   logic [N_WATCH-1:0]  win_unused;
   logic                rail_pos_on;
   logic                rail_neg_on;

   assign rail_pos_on = (st == SEQ_RAMP) || (st == SEQ_RUN);
   assign rail_neg_on = (st == SEQ_RUN);

   pseq_ctrl_fsm u_fsm (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .en_i        (en_i),
      .uvlo_i      (uvlo_i),
      .otemp_i     (otemp_i),
      .ramp_done_i (ramp_done),
      .trip_i      (|trip_vec),
      .st_o        (st)
   );

   pseq_span_timer #(.LIMIT(NEG_CYC)) u_ramp_tmr (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .run_i    (st == SEQ_RAMP),
      .last_o   (ramp_done),
      .window_o (ramp_win_unused)
   );

   pseq_span_timer #(.LIMIT(SOFT_CYC)) u_soft_tmr (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .run_i    (rail_pos_on),
      .last_o   (soft_last_unused),
      .window_o (soft_win)
   );

   assign flag_vec[W_POS] = pos_low_i;
   assign flag_vec[W_NEG] = neg_oor_i;
   assign arm_vec[W_POS]  = rail_pos_on;
   assign arm_vec[W_NEG]  = rail_neg_on;

   for (genvar g = 0; g < N_WATCH; g++) begin : g_watch
      pseq_span_timer #(.LIMIT(FILT_CYC)) u_filt (
         .clk_i    (clk_i),
         .rst_ni   (rst_ni),
         .run_i    (arm_vec[g] && flag_vec[g]),
         .last_o   (trip_vec[g]),
         .window_o (win_unused[g])
      );
   end

   assign pos_en_o     = rail_pos_on;
   assign neg_en_o     = rail_neg_on;
   assign soft_start_o = rail_pos_on && soft_win;
   assign discharge_o  = (st == SEQ_IDLE) || (st == SEQ_TRIP);
   assign fault_o      = (st == SEQ_TRIP);

   AST_NEG_NEEDS_POS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      neg_en_o |-> pos_en_o); // R4
   AST_SS_NEEDS_POS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      soft_start_o |-> pos_en_o); // R3
   AST_FAULT_RAILS_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
      fault_o |-> (!pos_en_o && !neg_en_o && discharge_o)); // R7
   AST_NEG_FILT_ARMED: assert property (@(posedge clk_i) disable iff (!rst_ni)
      trip_vec[W_NEG] |-> neg_en_o); // R6
   AST_TRIP_LATCHES: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (|trip_vec && en_i && !uvlo_i) |=> fault_o); // R5

endmodule

// File: tb/pwr_seq_supervisor_test.sv
`timescale 1ns/1ps
module pwr_seq_supervisor_test;
   localparam int CPM    = 10;
   localparam int NEG_MS = 3;
   localparam int SS_MS  = 1;
   localparam int FL_MS  = 2;
   localparam int NEG_C  = CPM * NEG_MS;  // 30
   localparam int SS_C   = CPM * SS_MS;   // 10
   localparam int FL_C   = CPM * FL_MS;   // 20

   // {pos_en, soft_start, neg_en, discharge, fault}
   localparam logic [4:0] V_OFF  = 5'b00010;
   localparam logic [4:0] V_TRIP = 5'b00011;
   localparam logic [4:0] V_SS   = 5'b11000;
   localparam logic [4:0] V_RAMP = 5'b10000;
   localparam logic [4:0] V_BOTH = 5'b10100;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic en = 1'b0, uvlo = 1'b0, otemp = 1'b0, plow = 1'b0, noor = 1'b0;
   logic pos_en, ss, neg_en, dis, flt;
   logic [4:0] obs;
   int tests = 0;
   int fails = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   pwr_seq_supervisor #(
      .CLKS_PER_MS(CPM), .NEG_DELAY_MS(NEG_MS), .SOFT_MS(SS_MS), .FILT_MS(FL_MS)
   ) uut (
      .clk_i(clk), .rst_ni(rst_n), .en_i(en), .uvlo_i(uvlo), .otemp_i(otemp),
      .pos_low_i(plow), .neg_oor_i(noor),
      .pos_en_o(pos_en), .soft_start_o(ss), .neg_en_o(neg_en),
      .discharge_o(dis), .fault_o(flt)
   );

   assign obs = {pos_en, ss, neg_en, dis, flt};

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input string req, input logic [4:0] exp);
      tests++;
      if (obs !== exp) begin
         fails++;
         $display("FAIL %s: outputs=%b expected=%b at %0t", req, obs, exp, $time);
      end
   endtask

   // off -> enable; leaves the bench at the first cycle of the ramp
   task automatic go_ramp();
      en = 1'b0; tick(1);
      en = 1'b1; tick(1);
   endtask

   task automatic go_both();
      go_ramp();
      tick(NEG_C);
   endtask

   task automatic t_reset();
      tick(1);
      chk("R1 reset state", V_OFF);
      rst_n = 1'b1;
      tick(2);
      chk("R1 idle after reset", V_OFF);
   endtask

   task automatic t_startup();
      go_ramp();
      chk("R2 positive start with soft-start", V_SS);
      tick(SS_C - 1);
      chk("R3 soft-start last cycle", V_SS);
      tick(1);
      chk("R3 soft-start released", V_RAMP);
      tick(NEG_C - SS_C - 1);
      chk("R4 negative still off one cycle before delay", V_RAMP);
      tick(1);
      chk("R4 negative on after delay", V_BOTH);
   endtask

   task automatic t_pos_filter();
      go_both();
      plow = 1'b1; tick(FL_C - 1);
      chk("R5 no fault one cycle short", V_BOTH);
      plow = 1'b0; tick(1);
      plow = 1'b1; tick(FL_C - 1);
      chk("R5 count restarted after one low cycle", V_BOTH);
      tick(1);
      chk("R5 fault after full window", V_TRIP);
      plow = 1'b0; tick(10);
      chk("R7 fault latched with flags clear", V_TRIP);
      en = 1'b0; tick(1);
      chk("R9 enable low clears fault", V_OFF);
      en = 1'b1; tick(1);
      chk("R9 restart after toggle", V_SS);
   endtask

   task automatic t_neg_filter();
      go_ramp();
      noor = 1'b1; tick(FL_C + 5);
      chk("R6 negative flag ignored during ramp", V_RAMP);
      noor = 1'b0; tick(NEG_C - FL_C - 5);
      chk("R6 negative converter on", V_BOTH);
      noor = 1'b1; tick(FL_C - 1);
      chk("R6 no fault one cycle short", V_BOTH);
      tick(1);
      chk("R6 negative fault latched", V_TRIP);
      noor = 1'b0;
   endtask

   task automatic t_otemp();
      go_both();
      otemp = 1'b1; tick(1);
      chk("R8 over-temperature trips at once", V_TRIP);
      otemp = 1'b0; tick(3);
      chk("R7 hold after over-temperature clears", V_TRIP);
      en = 1'b0; tick(1);
      otemp = 1'b1; en = 1'b1; tick(1);
      chk("R8 over-temperature blocks start-up", V_TRIP);
      otemp = 1'b0; en = 1'b0; tick(1);
      chk("R10 enable low from fault", V_OFF);
   endtask

   task automatic t_uvlo();
      go_both();
      uvlo = 1'b1; tick(1);
      chk("R11 lockout forces off without fault", V_OFF);
      tick(5);
      chk("R11 no start while locked out", V_OFF);
      uvlo = 1'b0; tick(1);
      chk("R11 start once lockout clears", V_SS);
      otemp = 1'b1; tick(1); otemp = 1'b0;
      chk("R8 trip from ramp", V_TRIP);
      uvlo = 1'b1; tick(1);
      chk("R11 lockout clears latched fault", V_OFF);
      uvlo = 1'b0; tick(1);
      chk("R9 power cycle restarts", V_SS);
   endtask

   task automatic t_en_low();
      go_ramp();
      tick(3);
      en = 1'b0; tick(1);
      chk("R10 enable low during ramp", V_OFF);
      go_both();
      en = 1'b0; tick(1);
      chk("R10 enable low with both rails on", V_OFF);
   endtask

   initial begin
      t_reset();
      t_startup();
      t_pos_filter();
      t_neg_filter();
      t_otemp();
      t_uvlo();
      t_en_low();
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         tests++;
         fails++;
         $display("FAIL watchdog: outputs=%b expected=completion", obs);
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

endmodule